// File: doc/BRIEF.md
# I2C-Controlled Two-Colour LED Pattern Sequencer

This block is an I2C target at a fixed 7-bit address that drives one red and one green indicator. The indicators follow a loop of four stages. A stage timer moves the loop to the next stage after a fixed number of system clocks. A single pattern byte holds four enable bits for each colour, one bit per stage. A colour is lit in every stage whose bit is set, and both colours may be lit in the same stage.

The host first writes the new pattern byte to the pattern register. The LEDs keep showing the old pattern. The new pattern is applied only when the host writes the value 1 to the commit register. At that moment the active pattern loads the pending byte and the loop restarts from stage 0.

SCL and SDA are oversampled with the system clock. The target only accepts write transfers. It pulls SDA low through an open-drain enable to acknowledge its address and each byte that it accepts.

Top module: `i2c_led_sequencer`

## Requirements
- R1: A write transfer to address 0x10 (first byte 0x20, bit 0 = 0 for write) is acknowledged by pulling SDA low during the ninth clock.
- R2: A read request to address 0x10 (first byte 0x21) and any transfer to another address are not acknowledged, and SDA stays released for the rest of that transfer.
- R3: A data byte written to register 8 is stored as the pending pattern only. The LED outputs do not change until a commit.
- R4: Writing the value 1 to register 7 copies the pending pattern into the active pattern and restarts the loop at stage 0 with a fresh stage period.
- R5: Writing any value other than 1 to register 7 leaves the active pattern and the LEDs unchanged.
- R6: The red LED is lit in stage s (0..3) exactly when bit 7-s of the active pattern is 1. Bit 7 maps to stage 0 and bit 4 to stage 3.
- R7: The green LED is lit in stage s exactly when bit 3-s of the active pattern is 1. Both colours may be lit in the same stage.
- R8: The stage index advances by one, modulo 4, every STAGE_TICKS system clocks.
- R9: After reset the active and pending patterns are 0xF0 (red lit in all four stages, green dark), and SDA is released.
- R10: A register number other than 7 or 8 is not acknowledged. The data that follows it has no effect.
- R11: The SDA pull-down enable changes only while SCL is low.
- R12: Every data byte in a write transfer is acknowledged, and each one is written to the register named in the register byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When 1, the open-drain pad pulls SDA low |
| led_red | output | 1 | Red indicator, 1 = lit |
| led_green | output | 1 | Green indicator, 1 = lit |

## Verification
The bound checker watches several rules on every cycle:
- The SDA pull-down stays still while SCL is high.
- The active pattern moves only on a commit, and each commit loads the pending byte and zeroes both the stage index and the tick counter.
- The stage index only ever steps by one, and the tick counter stays inside its period.

Some behaviour can only be shown by the bench's directed transfers:
- Address and register matching, including which bytes are acknowledged.
- How the pattern bits map to stages for each colour.
- That a bad commit value or an unknown register leaves the lights unchanged.

The bench checks stage timing by sampling the lights in the middle of each stage, counted from the clock edge that ended the commit byte.

// File: rtl/ledseq_pkg.sv
package ledseq_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
    localparam int NUM_STAGES = 4;
    localparam int STAGE_W   = $clog2(NUM_STAGES);

    localparam logic [BYTE_W-1:0] REG_PATTERN     = 8'd8;
    localparam logic [BYTE_W-1:0] REG_APPLY       = 8'd7;
    localparam logic [BYTE_W-1:0] APPLY_KEY       = 8'd1;
    localparam logic [BYTE_W-1:0] PATTERN_DEFAULT = 8'hF0;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_ADDR_ACK,
        BUS_REG,
        BUS_REG_ACK,
        BUS_DATA,
        BUS_DATA_ACK
    } bus_state_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] reg_id;
        logic [BYTE_W-1:0] value;
    } wr_req_t;

    typedef struct packed {
        logic red;
        logic green;
    } led_pair_t;

    function automatic logic reg_is_known(input logic [BYTE_W-1:0] r);
        return (r == REG_PATTERN) || (r == REG_APPLY);
    endfunction

    function automatic led_pair_t stage_lights(input logic [BYTE_W-1:0] pat,
                                               input logic [STAGE_W-1:0] stg);
        led_pair_t    res;
        logic [2:0]   red_pos;
        logic [2:0]   grn_pos;
        red_pos   = 3'd7 - {1'b0, stg};
        grn_pos   = 3'd3 - {1'b0, stg};
        res.red   = pat[red_pos];
        res.green = pat[grn_pos];
        return res;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now   = scl_pipe[STAGES-1];
    assign sda_now   = sda_pipe[STAGES-1];
    assign sda_q     = sda_now;
    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign start_det = scl_now & scl_d & sda_d & ~sda_now;
    assign stop_det  = scl_now & scl_d & ~sda_d & sda_now;

endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import ledseq_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h10
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sda_q,
    input  logic    scl_rise,
    input  logic    scl_fall,
    input  logic    start_det,
    input  logic    stop_det,
    output logic    sda_oe,
    output wr_req_t wr_req
);

    localparam logic [BYTE_W-1:0]    ADDR_WRITE = {DEV_ADDR, 1'b0};
    localparam logic [BIT_CNT_W-1:0] FULL_BYTE  = BIT_CNT_W'(BYTE_W);

    bus_state_e           state;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    shreg;
    logic [BYTE_W-1:0]    reg_sel;
    logic                 shifting;
    logic                 byte_done;

    assign shifting  = (state == BUS_ADDR) || (state == BUS_REG) || (state == BUS_DATA);
    assign byte_done = (bit_cnt == FULL_BYTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= BUS_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            reg_sel <= '0;
            sda_oe  <= 1'b0;
            wr_req  <= '0;
        end else begin
            wr_req.valid <= 1'b0;
            if (start_det) begin
                state   <= BUS_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= BUS_IDLE;
                sda_oe <= 1'b0;
            end else if (scl_rise) begin
                if (shifting && !byte_done) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_q};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (scl_fall) begin
                case (state)
                    BUS_ADDR: begin
                        if (byte_done) begin
                            if (shreg == ADDR_WRITE) begin
                                sda_oe <= 1'b1;
                                state  <= BUS_ADDR_ACK;
                            end else begin
                                state <= BUS_IDLE;
                            end
                        end
                    end
                    BUS_ADDR_ACK: begin
                        sda_oe  <= 1'b0;
                        state   <= BUS_REG;
                        bit_cnt <= '0;
                    end
                    BUS_REG: begin
                        if (byte_done) begin
                            if (reg_is_known(shreg)) begin
                                reg_sel <= shreg;
                                sda_oe  <= 1'b1;
                                state   <= BUS_REG_ACK;
                            end else begin
                                state <= BUS_IDLE;
                            end
                        end
                    end
                    BUS_REG_ACK: begin
                        sda_oe  <= 1'b0;
                        state   <= BUS_DATA;
                        bit_cnt <= '0;
                    end
                    BUS_DATA: begin
                        if (byte_done) begin
                            sda_oe        <= 1'b1;
                            state         <= BUS_DATA_ACK;
                            wr_req.valid  <= 1'b1;
                            wr_req.reg_id <= reg_sel;
                            wr_req.value  <= shreg;
                        end
                    end
                    BUS_DATA_ACK: begin
                        sda_oe  <= 1'b0;
                        state   <= BUS_DATA;
                        bit_cnt <= '0;
                    end
                    default: begin
                        state <= BUS_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pattern_bank.sv
module pattern_bank
    import ledseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    output logic [BYTE_W-1:0] shadow,
    output logic [BYTE_W-1:0] active,
    output logic              commit
);

    logic load_shadow;

    assign load_shadow = wr_req.valid && (wr_req.reg_id == REG_PATTERN);
    assign commit      = wr_req.valid && (wr_req.reg_id == REG_APPLY)
                         && (wr_req.value == APPLY_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= PATTERN_DEFAULT;
            active <= PATTERN_DEFAULT;
        end else begin
            if (load_shadow) begin
                shadow <= wr_req.value;
            end
            if (commit) begin
                active <= shadow;
            end
        end
    end

endmodule

// File: rtl/stage_timer.sv
module stage_timer
    import ledseq_pkg::*;
#(
    parameter int STAGE_TICKS = 1000,
    parameter int TICK_W      = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    output logic [STAGE_W-1:0] stage,
    output logic [TICK_W-1:0]  tick_cnt
);

    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(STAGE_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            stage    <= '0;
            tick_cnt <= '0;
        end else if (tick_cnt == LAST_TICK) begin
            tick_cnt <= '0;
            stage    <= stage + 1'b1;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_led_sequencer.sv
module i2c_led_sequencer
    import ledseq_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h10,
    parameter int         STAGE_TICKS = 1000000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic led_red,
    output logic led_green
);

    localparam int TICK_W = (STAGE_TICKS > 1) ? $clog2(STAGE_TICKS) : 1;

    logic               sda_q;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_det;
    logic               stop_det;
    wr_req_t            wr_req;
    logic [BYTE_W-1:0]  shadow;
    logic [BYTE_W-1:0]  active;
    logic               commit;
    logic [STAGE_W-1:0] stage_idx;
    logic [TICK_W-1:0]  tick_cnt;
    led_pair_t          lights;

    i2c_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_wr_target #(
        .DEV_ADDR(DEV_ADDR)
    ) u_target (
        .clk      (clk),
        .rst      (rst),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_oe   (sda_oe),
        .wr_req   (wr_req)
    );

    pattern_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_req(wr_req),
        .shadow(shadow),
        .active(active),
        .commit(commit)
    );

    stage_timer #(
        .STAGE_TICKS(STAGE_TICKS),
        .TICK_W     (TICK_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (commit),
        .stage   (stage_idx),
        .tick_cnt(tick_cnt)
    );

    assign lights    = stage_lights(active, stage_idx);
    assign led_red   = lights.red;
    assign led_green = lights.green;

endmodule

// File: rtl/ledseq_checker.sv
module ledseq_checker
    import ledseq_pkg::*;
#(
    parameter int STAGE_TICKS = 1000,
    parameter int TICK_W      = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               scl_i,
    input logic               sda_oe,
    input logic               commit,
    input logic [BYTE_W-1:0]  shadow,
    input logic [BYTE_W-1:0]  active,
    input logic [STAGE_W-1:0] stage,
    input logic [TICK_W-1:0]  tick_cnt
);

    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe)); // R11

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> $stable(active)); // R3

    AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active == $past(shadow))); // R4

    AST_COMMIT_RESTART: assert property (@(posedge clk) disable iff (rst)
        commit |=> (stage == '0 && tick_cnt == '0)); // R4

    AST_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(commit) && (stage != $past(stage))) |-> (stage == $past(stage) + 1'b1)); // R8

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
        tick_cnt <= TICK_W'(STAGE_TICKS - 1)); // R8

endmodule

bind i2c_led_sequencer ledseq_checker #(
    .STAGE_TICKS(STAGE_TICKS),
    .TICK_W     (TICK_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .commit  (commit),
    .shadow  (shadow),
    .active  (active),
    .stage   (stage_idx),
    .tick_cnt(tick_cnt)
);

// File: tb/sim_i2c_led_sequencer.sv
module sim_i2c_led_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int STAGE_LEN  = 64;
    localparam int HALF       = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_tb = 1'b1;
    logic sda_tb = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic led_red;
    logic led_green;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int byte_mark = 0;
    int commit_mark = 0;
    logic [7:0] cur_pat = 8'hF0;

    assign sda_bus = sda_tb & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_led_sequencer #(
        .STAGE_TICKS(STAGE_LEN)
    ) u0 (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_tb),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .led_red  (led_red),
        .led_green(led_green)
    );

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(posedge clk);
        #1;
    endtask

    task automatic check_bit(input string tag, input string what,
                             input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_tb = 1'b0;
        wait_cycles(HALF);
        scl_tb = 1'b0;
        wait_cycles(HALF);
    endtask

    task automatic bus_stop();
        sda_tb = 1'b0;
        wait_cycles(HALF);
        scl_tb = 1'b1;
        wait_cycles(HALF);
        sda_tb = 1'b1;
        wait_cycles(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_tb = b[i];
            wait_cycles(HALF);
            scl_tb = 1'b1;
            wait_cycles(HALF);
            scl_tb = 1'b0;
        end
        byte_mark = cyc;
        sda_tb = 1'b1;
        wait_cycles(HALF);
        scl_tb = 1'b1;
        wait_cycles(HALF/2);
        acked = ~sda_bus;
        wait_cycles(HALF/2);
        scl_tb = 1'b0;
        wait_cycles(HALF);
    endtask

    task automatic write_reg(input logic [7:0] first, input logic [7:0] regn,
                             input logic [7:0] val,
                             output logic a_ack, output logic r_ack, output logic d_ack);
        bus_start();
        send_byte(first, a_ack);
        send_byte(regn, r_ack);
        send_byte(val, d_ack);
        commit_mark = byte_mark;
        bus_stop();
    endtask

    // Sample four consecutive stages, counted from the last commit edge
    task automatic check_pattern(input string tag, input logic [7:0] pat);
        int k0;
        k0 = (cyc - commit_mark) / STAGE_LEN + 1;
        for (int j = 0; j < 4; j++) begin
            int k;
            int s;
            k = k0 + j;
            s = k % 4;
            wait_until(commit_mark + STAGE_LEN * k + STAGE_LEN / 2);
            check_bit(tag, $sformatf("red stage %0d", s), led_red, pat[7 - s]);
            check_bit(tag, $sformatf("green stage %0d", s), led_green, pat[3 - s]);
        end
    endtask

    task automatic test_reset();
        check_bit("R9", "sda released", sda_oe, 1'b0);
        commit_mark = cyc;
        check_pattern("R9", 8'hF0);
    endtask

    task automatic test_address();
        logic a, r, d;
        write_reg(8'h20, 8'd8, 8'hF0, a, r, d);
        check_bit("R1", "address ack", a, 1'b1);
        check_bit("R12", "data ack", d, 1'b1);
        write_reg(8'h22, 8'd8, 8'h0F, a, r, d);
        check_bit("R2", "other address ack", a, 1'b0);
        check_bit("R2", "other address data ack", d, 1'b0);
        bus_start();
        send_byte(8'h21, a);
        check_bit("R2", "read ack", a, 1'b0);
        send_byte(8'hFF, d);
        check_bit("R2", "read follow-on ack", d, 1'b0);
        bus_stop();
        check_bit("R2", "sda released after read", sda_oe, 1'b0);
    endtask

    task automatic test_shadow_only();
        logic a, r, d;
        int keep;
        keep = commit_mark;
        write_reg(8'h20, 8'd8, 8'h0F, a, r, d);
        check_bit("R3", "pattern reg ack", r, 1'b1);
        commit_mark = keep;
        check_pattern("R3", cur_pat);
    endtask

    task automatic test_bad_commit();
        logic a, r, d;
        int keep;
        keep = commit_mark;
        write_reg(8'h20, 8'd7, 8'h02, a, r, d);
        check_bit("R5", "apply reg ack", r, 1'b1);
        commit_mark = keep;
        check_pattern("R5", cur_pat);
    endtask

    task automatic test_commit(input logic [7:0] pat);
        logic a, r, d;
        write_reg(8'h20, 8'd8, pat, a, r, d);
        write_reg(8'h20, 8'd7, 8'h01, a, r, d);
        check_bit("R4", "commit data ack", d, 1'b1);
        cur_pat = pat;
        check_pattern("R4", pat);
        check_pattern("R6", pat);
        check_pattern("R7", pat);
        check_pattern("R8", pat);
    endtask

    task automatic test_bad_reg();
        logic a, r, d;
        int keep;
        keep = commit_mark;
        write_reg(8'h20, 8'd5, 8'h01, a, r, d);
        check_bit("R10", "reg 5 ack", r, 1'b0);
        check_bit("R10", "reg 5 data ack", d, 1'b0);
        write_reg(8'h20, 8'd9, 8'hFF, a, r, d);
        check_bit("R10", "reg 9 ack", r, 1'b0);
        commit_mark = keep;
        check_pattern("R10", cur_pat);
    endtask

    task automatic test_multi_byte();
        logic a, r, d, d2;
        bus_start();
        send_byte(8'h20, a);
        send_byte(8'd8, r);
        send_byte(8'h11, d);
        send_byte(8'h48, d2);
        bus_stop();
        check_bit("R12", "first data ack", d, 1'b1);
        check_bit("R12", "second data ack", d2, 1'b1);
        write_reg(8'h20, 8'd7, 8'h01, a, r, d);
        cur_pat = 8'h48;
        check_pattern("R12", 8'h48);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        test_reset();
        test_address();
        test_shadow_only();
        test_bad_commit();
        test_commit(8'hA6);
        test_commit(8'h81);
        test_bad_reg();
        test_commit(8'h18);
        test_shadow_only();
        test_multi_byte();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule